// File: doc/BRIEF.md
# Timer Compare Match Output Unit

This block pairs a 16-bit up-counter with two compare channels, A and B. On every clock the counter steps. When its value equals a channel's compare register, that channel's one-bit compare output changes one clock later, as its two-bit output mode selects: it toggles, clears or sets. Mode 00 disconnects the compare output from the pin and leaves the pin showing the port data bit. The compare output then holds its value, so re-selecting a nonzero mode puts the last state back on the pin.

Each pin has a direction bit. When the direction bit is clear, the output enable is low and the pin is tri-stated, whatever the output mode. The waveform mode is four bits wide and is split across two control registers. Value 0100 makes channel A's compare register the counter's TOP (clear on compare). Every other value lets the counter run freely from 0 to 0xFFFF and wrap. Software loads all registers through a single-cycle write port.

Top module: `cmp_out_unit`

## Requirements
- R1: When reset is applied, the counter reads 0, both compare outputs are 0, all registers are 0, and both output enables and both pin values are low.
- R2: In free-running mode the counter rises by one on each clock and goes from 0xFFFF to 0.
- R3: With waveform mode 0100, the counter goes to 0 on the clock that follows the cycle in which it equals the channel A compare value.
- R4: Output mode 01 inverts the channel's compare output on the clock after the counter equals that channel's compare value.
- R5: Output mode 10 sets the channel's compare output to 0 on the clock after a match.
- R6: Output mode 11 sets the channel's compare output to 1 on the clock after a match.
- R7: With output mode 00 the pin value is the channel's port data bit, and matches leave the compare output unchanged. When a nonzero mode is selected again, the held value reappears on the pin.
- R8: The pin register is at address 4. Bit 0 is A's direction, bit 1 is B's direction, bit 2 is A's port data and bit 3 is B's port data. Each output enable follows its own direction bit only.
- R9: Control register A is at address 0. It holds A's mode in bits 7:6, B's mode in bits 5:4 and waveform bits 1:0. Control register B is at address 1 and holds waveform bits 3:2 in its bits 4:3. The compare registers for A and B are at addresses 2 and 3. Any nonzero mode puts the compare output on the pin in place of the port bit.
- R10: A compare output changes only on the clock after a match of its own channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| count | output | 16 | Current counter value |
| pin_a_out | output | 1 | Channel A pin value |
| pin_a_oe | output | 1 | Channel A output enable (low means tri-stated) |
| pin_b_out | output | 1 | Channel B pin value |
| pin_b_oe | output | 1 | Channel B output enable (low means tri-stated) |

## Verification
A wrong compare-output state cannot be seen while the mode is 00. It shows up at the pin as soon as a nonzero mode is selected again, or one clock after the next match. A toggle that fires twice, or a missed match, therefore shows only after the following match, up to one counter period later. A wrong counter step or TOP handling is visible on `count` in the very next cycle. A wrongly placed mode or waveform field changes which pin reacts, or the period of the count sequence, within one period.

// File: rtl/cmo_pkg.sv
package cmo_pkg;

  typedef enum logic [1:0] {
    OM_OFF    = 2'b00,
    OM_TOGGLE = 2'b01,
    OM_CLEAR  = 2'b10,
    OM_SET    = 2'b11
  } out_mode_e;

  localparam int ADR_CTRL_A = 0;
  localparam int ADR_CTRL_B = 1;
  localparam int ADR_CMP_A  = 2;
  localparam int ADR_PIN    = 4;

  localparam logic [3:0] WAVE_CTC = 4'b0100;

  // Four-bit waveform mode gathered from both control registers.
  function automatic logic [3:0] wave_mode(input logic [7:0] ctl_a, input logic [7:0] ctl_b);
    return {ctl_b[4:3], ctl_a[1:0]};
  endfunction

  function automatic logic wave_is_ctc(input logic [3:0] wm);
    return wm == WAVE_CTC;
  endfunction

  // Compare output value after a match under a given mode.
  function automatic logic next_oc(input logic [1:0] mode, input logic cur);
    case (out_mode_e'(mode))
      OM_TOGGLE: return ~cur;
      OM_CLEAR:  return 1'b0;
      OM_SET:    return 1'b1;
      default:   return cur;
    endcase
  endfunction

endpackage

// File: rtl/cmo_counter.sv
module cmo_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctc_on,
  input  logic [W-1:0] top_val,
  output logic [W-1:0] cnt
);

  logic [W-1:0] cnt_q;
  logic         at_top;

  assign at_top = ctc_on && (cnt_q == top_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (at_top) cnt_q <= '0;
    else             cnt_q <= cnt_q + W'(1);
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/cmo_channel.sv
module cmo_channel #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp,
  input  logic [1:0]   mode,
  input  logic         dir,
  input  logic         port,
  output logic         match,
  output logic         oc,
  output logic         pin_out,
  output logic         pin_oe
);
  import cmo_pkg::*;

  logic oc_q;

  assign match = (cnt == cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     oc_q <= 1'b0;
    else if (match) oc_q <= next_oc(mode, oc_q);
  end

  assign oc      = oc_q;
  assign pin_out = (mode != OM_OFF) ? oc_q : port;
  assign pin_oe  = dir;

endmodule

// File: rtl/cmp_out_unit.sv
module cmp_out_unit #(
  parameter int W      = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  output logic [W-1:0]      count,
  output logic              pin_a_out,
  output logic              pin_a_oe,
  output logic              pin_b_out,
  output logic              pin_b_oe
);
  import cmo_pkg::*;

  localparam int NUM_CH   = 2;
  localparam int MODE_TOP = 7;

  logic [7:0]        ctrl_a_q, ctrl_b_q;
  logic [W-1:0]      cmp_q [NUM_CH];
  logic [NUM_CH-1:0] dir_q, port_q;
  logic [NUM_CH-1:0] match_v, oc_v, out_v, oe_v;
  logic [1:0]        mode_v [NUM_CH];

  // Named internal events for the bound checker.
  logic [3:0]   wave_m;
  logic         ctc_on;
  logic [W-1:0] top_val;
  logic         match_a, match_b, oc_a, oc_b;
  logic [1:0]   mode_a, mode_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_a_q <= '0;
      ctrl_b_q <= '0;
      dir_q    <= '0;
      port_q   <= '0;
      for (int i = 0; i < NUM_CH; i++) cmp_q[i] <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(ADR_CTRL_A)) ctrl_a_q <= wr_data[7:0];
      if (wr_addr == ADDR_W'(ADR_CTRL_B)) ctrl_b_q <= wr_data[7:0];
      if (wr_addr == ADDR_W'(ADR_PIN)) begin
        dir_q  <= wr_data[NUM_CH-1:0];
        port_q <= wr_data[2*NUM_CH-1:NUM_CH];
      end
      for (int i = 0; i < NUM_CH; i++)
        if (wr_addr == ADDR_W'(ADR_CMP_A + i)) cmp_q[i] <= wr_data;
    end
  end

  assign wave_m  = wave_mode(ctrl_a_q, ctrl_b_q);
  assign ctc_on  = wave_is_ctc(wave_m);
  assign top_val = cmp_q[0];

  cmo_counter #(.W(W)) cnt_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctc_on  (ctc_on),
    .top_val (top_val),
    .cnt     (count)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign mode_v[i] = ctrl_a_q[MODE_TOP-2*i -: 2];

    cmo_channel #(.W(W)) ch_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .cnt     (count),
      .cmp     (cmp_q[i]),
      .mode    (mode_v[i]),
      .dir     (dir_q[i]),
      .port    (port_q[i]),
      .match   (match_v[i]),
      .oc      (oc_v[i]),
      .pin_out (out_v[i]),
      .pin_oe  (oe_v[i])
    );
  end

  assign match_a = match_v[0];
  assign match_b = match_v[1];
  assign oc_a    = oc_v[0];
  assign oc_b    = oc_v[1];
  assign mode_a  = mode_v[0];
  assign mode_b  = mode_v[1];

  assign pin_a_out = out_v[0];
  assign pin_a_oe  = oe_v[0];
  assign pin_b_out = out_v[1];
  assign pin_b_oe  = oe_v[1];

endmodule

// File: rtl/cmo_checker.sv
module cmo_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] count,
  input logic [W-1:0] top_val,
  input logic         ctc_on,
  input logic         match_a,
  input logic         match_b,
  input logic [1:0]   mode_a,
  input logic [1:0]   mode_b,
  input logic         oc_a,
  input logic         oc_b
);

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(ctc_on && count == top_val) && count != '1) |=> count == $past(count) + W'(1));

  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(ctc_on && count == top_val) && count == '1) |=> count == '0);

  p_ctc_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctc_on && count == top_val) |=> count == '0);

  p_toggle_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (match_a && mode_a == 2'b01) |=> oc_a != $past(oc_a));

  p_toggle_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (match_b && mode_b == 2'b01) |=> oc_b != $past(oc_b));

  p_clear_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (match_a && mode_a == 2'b10) |=> !oc_a);

  p_clear_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (match_b && mode_b == 2'b10) |=> !oc_b);

  p_set_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (match_a && mode_a == 2'b11) |=> oc_a);

  p_set_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (match_b && mode_b == 2'b11) |=> oc_b);

  p_hold_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_a == 2'b00) |=> $stable(oc_a));

  p_quiet_a_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !match_a |=> $stable(oc_a));

  p_quiet_b_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !match_b |=> $stable(oc_b));

endmodule

bind cmp_out_unit cmo_checker #(.W(W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .count   (count),
  .top_val (top_val),
  .ctc_on  (ctc_on),
  .match_a (match_a),
  .match_b (match_b),
  .mode_a  (mode_a),
  .mode_b  (mode_b),
  .oc_a    (oc_a),
  .oc_b    (oc_b)
);

// File: tb/cmp_out_unit_tb.sv
`timescale 1ns/1ps
module cmp_out_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] count;
  logic        pin_a_out, pin_a_oe, pin_b_out, pin_b_oe;

  int n_chk = 0;
  int n_err = 0;
  bit timed_out = 1'b0;

  always #2.5 clk = ~clk;

  cmp_out_unit dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .count     (count),
    .pin_a_out (pin_a_out),
    .pin_a_oe  (pin_a_oe),
    .pin_b_out (pin_b_out),
    .pin_b_oe  (pin_b_oe)
  );

  // {channel, mode[1:0], pin before match, pin after match}
  localparam logic [4:0] VEC [0:8] = '{
    5'b0_11_0_1, 5'b0_11_1_1, 5'b0_01_1_0, 5'b0_01_0_1, 5'b0_10_1_0,
    5'b1_01_0_1, 5'b1_11_1_1, 5'b1_10_1_0, 5'b1_01_0_1
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_cnt(input logic [15:0] v);
    int guard = 0;
    while (count !== v && !timed_out) begin
      @(negedge clk);
      guard++;
      if (guard > 70000) begin
        timed_out = 1'b1;
        n_err++;
        $display("FAIL wait for count=%0h timed out", v);
      end
    end
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    #(200000 * 5);
    n_err++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 count", 32'(count), 0);
    chk("R1 oe_a", 32'(pin_a_oe), 0);
    chk("R1 oe_b", 32'(pin_b_oe), 0);
    chk("R1 out_a", 32'(pin_a_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 first step", 32'(count), 1);

    // R2: free-running wrap
    wait_cnt(16'hFFFF);
    @(negedge clk);
    chk("R2 wrap", 32'(count), 0);

    // R8/R7: directions on, port A=1, port B=0, modes off
    wr(3'd4, 16'h0007);
    chk("R7 port a", 32'(pin_a_out), 1);
    chk("R7 port b", 32'(pin_b_out), 0);
    chk("R8 oe a", 32'(pin_a_oe), 1);
    chk("R8 oe b", 32'(pin_b_oe), 1);

    // R3/R9: clear-on-compare with TOP=100 via control B bit 3
    wr(3'd2, 16'd100);
    wr(3'd3, 16'd50);
    wr(3'd1, 16'h0008);
    wait_cnt(16'd100);
    @(negedge clk);
    chk("R3 ctc return", 32'(count), 0);

    for (int k = 0; k < 9; k++) begin
      logic       ch;
      logic [1:0] md;
      string      tag;
      ch = VEC[k][4];
      md = VEC[k][3:2];
      tag = (md == 2'b01) ? "R4" : (md == 2'b10) ? "R5" : "R6";
      wait_cnt(16'd2);
      wr(3'd0, 16'(md) << (6 - 2 * ch));
      wait_cnt(ch ? 16'd50 : 16'd100);
      chk("R9 takeover before match", 32'(ch ? pin_b_out : pin_a_out), 32'(VEC[k][1]));
      @(negedge clk);
      chk(tag, 32'(ch ? pin_b_out : pin_a_out), 32'(VEC[k][0]));
    end

    // R7: disconnect, match ignored, reconnect restores held value (oc_b=1)
    wait_cnt(16'd2);
    wr(3'd0, 16'h0000);
    chk("R7 off a shows port", 32'(pin_a_out), 1);
    chk("R7 off b shows port", 32'(pin_b_out), 0);
    wait_cnt(16'd50);
    @(negedge clk);
    chk("R7 match while off", 32'(pin_b_out), 0);
    wait_cnt(16'd2);
    wr(3'd0, 16'h0020);
    chk("R7 reconnect restores", 32'(pin_b_out), 1);
    wait_cnt(16'd50);
    @(negedge clk);
    chk("R5 clear after reconnect", 32'(pin_b_out), 0);

    // R8: direction bits gate the output enables independently
    wr(3'd4, 16'h000C);
    chk("R8 tri a", 32'(pin_a_oe), 0);
    chk("R8 tri b", 32'(pin_b_oe), 0);
    wr(3'd4, 16'h0001);
    chk("R8 only a", 32'(pin_a_oe), 1);
    chk("R8 b stays tri", 32'(pin_b_oe), 0);

    // R2/R9: waveform 0101 is not CTC, counter passes TOP
    wait_cnt(16'd2);
    wr(3'd0, 16'h0001);
    wait_cnt(16'd100);
    @(negedge clk);
    chk("R2 mode 0101 free run", 32'(count), 101);

    report();
    $finish;
  end

endmodule